// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port. One side is a simple CPU register port: a select, a read strobe, a write strobe, write data and combinational read data. The other side takes single-cycle event strobes from the transmitter and the receiver. The block keeps these bits: transmit-buffer-empty, transmit-complete, receive-buffer-full, three receive error flags, the multi-processor tag captured from the last received frame, and the multi-processor tag that goes out with each transmitted frame.

Hardware events set the flags. The errors clear only through a guarded software write. Software has to read a set error flag as 1 before a write of 0 to that bit clears it. A new hardware set of the flag cancels any earlier read, so software must read the flag again. The transmit-complete flag follows the transmit enable and the end of the last character. The receive-buffer-full and transmit-buffer-empty flags follow the data register traffic. If a hardware set and a clear happen in the same cycle, the set wins.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the register reads 0x84.
- R2: Bit layout: b7 transmit-buffer-empty, b6 receive-buffer-full, b5 overrun error, b4 framing error, b3 parity error, b2 transmit-complete, b1 received multi-processor tag, b0 transmit multi-processor tag.
- R3: A strobe on par_err_i, frm_err_i or ovr_err_i sets the matching error flag, and the flag stays 1 until software clears it.
- R4: A register write with 0 in an error bit clears that flag only if a read of this register returned the flag as 1 since the flag was last set. A write of 0 without such a read leaves the flag at 1. A write of 1 leaves the flag unchanged.
- R5: A hardware set of an error flag in the same cycle as a qualified clear leaves the flag at 1, and it cancels the earlier read, so a later write of 0 has no effect until the flag is read again.
- R6: The transmit-complete flag is 1 in every cycle after a cycle with tx_en_i = 0. It stays 1 when tx_en_i rises.
- R7: tdr_wr_i with tx_en_i = 1 clears transmit-complete. tdr_wr_i with tx_en_i = 0 leaves it at 1. Register writes never change it.
- R8: tx_last_i sets transmit-complete only if transmit-buffer-empty is 1 and tdr_wr_i is 0 in that cycle. Otherwise the flag keeps its value.
- R9: tdr_wr_i clears transmit-buffer-empty and tx_load_i sets it. If both arrive in the same cycle, the flag ends at 1.
- R10: rx_done_i sets receive-buffer-full and rdr_rd_i clears it. If both arrive in the same cycle, the flag ends at 1.
- R11: On rx_done_i with rx_en_i = 1, the received tag bit takes rx_mpb_i. While rx_en_i = 0 it holds its value. Register writes do not change it.
- R12: Register writes load wdata_i[0] into the transmit tag bit, which is driven on tx_mpb_o and read back at b0.
- R13: rdata_o is 0 unless sel_i and rd_en_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| tx_en_i | input | 1 | Transmitter enable |
| tdr_wr_i | input | 1 | Transmit data register written |
| tx_load_i | input | 1 | Transmit data moved into the shifter |
| tx_last_i | input | 1 | Last bit of a character on the line |
| tx_mpb_o | output | 1 | Multi-processor tag for outgoing frames (1 ID, 0 data) |
| rx_en_i | input | 1 | Receiver enable |
| rx_done_i | input | 1 | Frame received into the receive data register |
| rx_mpb_i | input | 1 | Multi-processor tag of the received frame |
| rdr_rd_i | input | 1 | Receive data register read |
| par_err_i | input | 1 | Parity error strobe |
| frm_err_i | input | 1 | Framing error strobe |
| ovr_err_i | input | 1 | Overrun error strobe |

## Verification
The assertions check the local rules on every cycle:
- a set strobe gives a 1 on the next cycle;
- an error flag can fall only after it was read;
- a write of 1 leaves an error flag unchanged;
- transmit-complete is 1 after any cycle with the transmitter disabled;
- the received tag holds while the receiver is disabled;
- a register write reaches the transmit tag.

Some behaviours depend on a sequence of accesses, and only the bench's scenarios can show them. Examples are the write of 0 that has no effect without a prior read, the read that hardware cancels in a set/clear collision, a TDR write that coincides with the last bit, and the full bit layout seen through the read port.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int NUM_ERR = 3;

  localparam int B_MPBT = 0;
  localparam int B_MPB  = 1;
  localparam int B_TEND = 2;
  localparam int B_ERR0 = 3;  // parity, framing, overrun follow
  localparam int B_RDRF = 6;
  localparam int B_TDRE = 7;

  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'((1 << B_TDRE) | (1 << B_TEND));

  typedef struct packed {
    logic               tdre;
    logic               rdrf;
    logic [NUM_ERR-1:0] err;   // [0] parity, [1] framing, [2] overrun
    logic               tend;
    logic               mpb;
    logic               mpbt;
  } stat_t;
endpackage

// File: rtl/uart_err_flag.sv
module uart_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, seen_q;
  logic clr;

  assign clr = wr_hit_i && !wbit_i && seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      if (set_i || clr)            seen_q <= 1'b0;
      else if (rd_hit_i && flag_q) seen_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);  // R3
  AST_CLR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !set_i && !(wr_hit_i && !wbit_i)) |=> flag_q);  // R4
  AST_W1_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && wbit_i && !set_i) |=> $stable(flag_q));  // R4
  AST_SET_DROPS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !seen_q);  // R5
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic tdr_wr_i,
  input  logic tx_load_i,
  input  logic tx_last_i,
  output logic tdre_o,
  output logic tend_o
);
  logic tdre_q, tend_q;
  logic tend_set, tend_clr;

  // last bit with nothing queued means the line goes idle
  assign tend_set = !tx_en_i || (tx_last_i && tdre_q && !tdr_wr_i);
  assign tend_clr = tdr_wr_i && tx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      if (tx_load_i)     tdre_q <= 1'b1;
      else if (tdr_wr_i) tdre_q <= 1'b0;

      if (tend_set)      tend_q <= 1'b1;
      else if (tend_clr) tend_q <= 1'b0;
    end
  end

  assign tdre_o = tdre_q;
  assign tend_o = tend_q;

  AST_TEND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> tend_q);  // R6
  AST_TEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdr_wr_i && tx_en_i) |=> !tend_q);  // R7
  AST_TEND_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !tdre_q && !tdr_wr_i) |=> $stable(tend_q));  // R8
  AST_TDRE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> tdre_q);  // R9
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic rx_done_i,
  input  logic rx_mpb_i,
  input  logic rdr_rd_i,
  output logic rdrf_o,
  output logic mpb_o
);
  logic rdrf_q, mpb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdrf_q <= 1'b0;
      mpb_q  <= 1'b0;
    end else begin
      if (rx_done_i)     rdrf_q <= 1'b1;
      else if (rdr_rd_i) rdrf_q <= 1'b0;

      if (rx_done_i && rx_en_i) mpb_q <= rx_mpb_i;
    end
  end

  assign rdrf_o = rdrf_q;
  assign mpb_o  = mpb_q;

  AST_RDRF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> rdrf_q);  // R10
  AST_MPB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> $stable(mpb_q));  // R11
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic              tx_en_i,
  input  logic              tdr_wr_i,
  input  logic              tx_load_i,
  input  logic              tx_last_i,
  output logic              tx_mpb_o,
  input  logic              rx_en_i,
  input  logic              rx_done_i,
  input  logic              rx_mpb_i,
  input  logic              rdr_rd_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              ovr_err_i
);
  logic               rd_hit, wr_hit;
  logic [NUM_ERR-1:0] err_set, err_q;
  logic               mpbt_q;
  stat_t              stat;

  assign rd_hit  = sel_i && rd_en_i;
  assign wr_hit  = sel_i && wr_en_i;
  assign err_set = {ovr_err_i, frm_err_i, par_err_i};

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    uart_err_flag i_err (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (err_set[i]),
      .rd_hit_i(rd_hit),
      .wr_hit_i(wr_hit),
      .wbit_i  (wdata_i[B_ERR0+i]),
      .flag_o  (err_q[i])
    );
  end

  uart_tx_flags i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .tdr_wr_i (tdr_wr_i),
    .tx_load_i(tx_load_i),
    .tx_last_i(tx_last_i),
    .tdre_o   (stat.tdre),
    .tend_o   (stat.tend)
  );

  uart_rx_flags i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_en_i  (rx_en_i),
    .rx_done_i(rx_done_i),
    .rx_mpb_i (rx_mpb_i),
    .rdr_rd_i (rdr_rd_i),
    .rdrf_o   (stat.rdrf),
    .mpb_o    (stat.mpb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mpbt_q <= STAT_RST[B_MPBT];
    else if (wr_hit) mpbt_q <= wdata_i[B_MPBT];
  end

  assign stat.err  = err_q;
  assign stat.mpbt = mpbt_q;
  assign tx_mpb_o  = mpbt_q;
  assign rdata_o   = rd_hit ? stat : '0;

  AST_MPBT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> tx_mpb_o == $past(wdata_i[B_MPBT]));  // R12
  AST_MPBT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(tx_mpb_o));  // R12
endmodule

// File: tb/test_uart_stat_reg.sv
module test_uart_stat_reg;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_en = 1'b0, rx_en = 1'b0, rx_mpb = 1'b0;
  logic       tx_mpb;
  // ev bits: 0 par, 1 frm, 2 ovr, 3 tdr_wr, 4 tx_load, 5 tx_last, 6 rx_done, 7 rdr_rd
  logic [7:0] ev = '0;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_reg i_uart_stat_reg (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_en_i(rd), .wr_en_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_en_i(tx_en), .tdr_wr_i(ev[3]),
    .tx_load_i(ev[4]), .tx_last_i(ev[5]), .tx_mpb_o(tx_mpb), .rx_en_i(rx_en),
    .rx_done_i(ev[6]), .rx_mpb_i(rx_mpb), .rdr_rd_i(ev[7]),
    .par_err_i(ev[0]), .frm_err_i(ev[1]), .ovr_err_i(ev[2])
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); sel = 1'b1; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); sel = 1'b0; rd = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic wr_ev(input logic [7:0] v, input logic [7:0] m);
    @(negedge clk); sel = 1'b1; wr = 1'b1; wdata = v; ev = m;
    @(negedge clk); sel = 1'b0; wr = 1'b0; ev = '0;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    wr_ev(v, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 reset value", 8'h84);
    @(negedge clk); sel = 1'b1; rd = 1'b0;
    #1 chk("R13 select without read", rdata, 8'h00);
    sel = 1'b0; rd = 1'b1;
    #1 chk("R13 read without select", rdata, 8'h00);
    rd = 1'b0;
  endtask

  task automatic t_err_guard;
    pulse(8'h02);
    wr_reg(8'h00);
    rd_chk("R4 write0 without read keeps framing", 8'h94);
    wr_reg(8'hFF);
    rd_chk("R4 write1 keeps framing, R12 b0", 8'h95);
    wr_reg(8'hEE);
    rd_chk("R4 write0 after read clears framing", 8'h84);
    pulse(8'h01);
    rd_chk("R3 parity at b3", 8'h8C);
    wr_reg(8'h00);
    rd_chk("R4 parity cleared", 8'h84);
  endtask

  task automatic t_set_wins;
    pulse(8'h04);
    rd_chk("R3 overrun at b5", 8'hA4);
    wr_ev(8'h00, 8'h04);
    wr_reg(8'h00);
    rd_chk("R5 set wins and read cancelled", 8'hA4);
    wr_reg(8'h00);
    rd_chk("R5 clear after fresh read", 8'h84);
    pulse(8'h07);
    rd_chk("R2 all error bits", 8'hBC);
    wr_reg(8'h00);
    rd_chk("R4 all errors cleared", 8'h84);
  endtask

  task automatic t_tx;
    @(negedge clk); tx_en = 1'b1;
    rd_chk("R6 complete stays on enable", 8'h84);
    pulse(8'h08);
    rd_chk("R7 R9 TDR write clears both", 8'h00);
    wr_reg(8'h04);
    rd_chk("R7 register write ignored", 8'h00);
    pulse(8'h20);
    rd_chk("R8 last bit with data queued", 8'h00);
    pulse(8'h10);
    rd_chk("R9 load sets empty", 8'h80);
    pulse(8'h20);
    rd_chk("R8 last bit with empty buffer", 8'h84);
    pulse(8'h18);
    rd_chk("R9 load wins over TDR write", 8'h80);
    pulse(8'h28);
    rd_chk("R8 last bit with TDR write", 8'h00);
    pulse(8'h10);
    rd_chk("R9 reload", 8'h80);
    @(negedge clk); tx_en = 1'b0;
    rd_chk("R6 complete set when disabled", 8'h84);
    pulse(8'h08);
    rd_chk("R7 TDR write while disabled", 8'h04);
    pulse(8'h10);
    rd_chk("R9 restore empty", 8'h84);
  endtask

  task automatic t_rx;
    @(negedge clk); rx_en = 1'b1; rx_mpb = 1'b1;
    pulse(8'h40);
    rd_chk("R10 R11 frame with ID tag", 8'hC6);
    pulse(8'h80);
    rd_chk("R10 data read clears full", 8'h86);
    @(negedge clk); rx_en = 1'b0; rx_mpb = 1'b0;
    pulse(8'h40);
    rd_chk("R11 tag held while disabled", 8'hC6);
    pulse(8'hC0);
    rd_chk("R10 set wins over read", 8'hC6);
    wr_reg(8'h00);
    rd_chk("R11 write ignored", 8'hC6);
    @(negedge clk); rx_en = 1'b1;
    pulse(8'h40);
    rd_chk("R11 data tag captured", 8'hC4);
    pulse(8'h80);
    rd_chk("R10 cleared", 8'h84);
  endtask

  task automatic t_mpbt;
    wr_reg(8'h01);
    chk("R12 tx tag output high", {7'b0, tx_mpb}, 8'h01);
    rd_chk("R12 tx tag readback", 8'h85);
    wr_reg(8'h00);
    chk("R12 tx tag output low", {7'b0, tx_mpb}, 8'h00);
    rd_chk("R12 tx tag cleared", 8'h84);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_err_guard();
    t_set_wins();
    t_tx();
    t_rx();
    t_mpbt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule